// File: doc/BRIEF.md
# Interrupt Priority and Wake Arbiter

This block decides which pending interrupt a processor core takes next and whether a halted core must resume. Every cycle it looks at a vector of pending requests, the core's machine-state bits (external enable, hypervisor state, problem state, critical enable), a set of partition-control enables, the halted flag, a stop-state exit-control bit, a resume-as-reset flag, an event-branch global enable and a flag telling whether hypervisor mode exists. It returns one interrupt identifier with a valid bit, and a separate wake signal.

Priority is not one fixed list. The combinational selector first picks an arbitration mode: RUN (core not halted), HALT_GATED (halted, exit-control set), HALT_OPEN (halted, exit-control clear, external enable set) and HALT_QUIET (halted, exit-control clear, external enable clear). The mode is re-evaluated every cycle from the inputs alone; the transition RUN to any HALT mode follows the halted flag, HALT_GATED versus the other two follows exit-control, and HALT_OPEN versus HALT_QUIET follows the external enable. In HALT_QUIET the core is woken without any delivery and resumes at the next instruction. One register stage holds the identifier, valid and wake.

Top module: `ivp_arbiter`

## Requirements
- R1: A pending external reset (pend bit 0) is always delivered as identifier 1, in every mode and whatever the enable bits.
- R2: Source at pend bit k is reported as identifier k+1; bit order is reset 0, machine check 1, hypervisor decrementer 2, hypervisor virtualization 3, external 4, critical external 5, watchdog 6, critical doorbell 7, fixed-interval timer 8, programmable-interval timer 9, decrementer 10, privileged doorbell 11, hypervisor doorbell 12, performance monitor 13, thermal 14, event branch 15, hypervisor maintenance 16. With nothing selected, irq_valid is 0 and irq_id is 0.
- R3: In HALT_GATED, after reset the order is: external (needs wk_ext, blocked when hext_blk and hv and not pr), decrementer (wk_dec), machine check then hypervisor maintenance (both wk_fault), privileged doorbell (wk_pdb), hypervisor doorbell (wk_hdb), hypervisor virtualization (wk_hvirt); otherwise nothing.
- R4: In HALT_OPEN the selection follows the RUN rules.
- R5: In HALT_QUIET only reset may be delivered; wake is still raised when any source other than event branch is pending.
- R6: In RUN, machine check ranks right after reset and ignores the external enable. Hypervisor maintenance is never selected outside HALT_GATED.
- R7: The asynchronous condition is ee or resume_rst. Hypervisor decrementer needs hdec_ie and (asynchronous or not hv) and ranks above hypervisor virtualization, which needs hvirt_ie and the same condition.
- R8: External is taken when (asynchronous and not (hext_blk and hv and not pr)) or (hv_present and not hv and not ext_route).
- R9: Critical external is taken only with ce set and ranks after external.
- R10: Under the asynchronous condition, the rest rank: watchdog, critical doorbell, fixed-interval, programmable-interval, decrementer, privileged doorbell, hypervisor doorbell, performance monitor, thermal, event branch; without it none of them is taken.
- R11: Event branch additionally needs pr and ebb_ge.
- R12: wake is 1 exactly when halted and (an interrupt is selected, or exit-control is clear and a source other than event branch is pending); it is 0 while not halted.
- R13: Outputs appear one clock after the inputs; reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend | input | 17 | Pending requests, bit order in R2 |
| ee | input | 1 | External enable |
| hv | input | 1 | Hypervisor state |
| pr | input | 1 | Problem state |
| ce | input | 1 | Critical enable |
| halted | input | 1 | Core is halted |
| exit_ctl | input | 1 | Stop-state exit control |
| resume_rst | input | 1 | Resume-as-reset flag |
| ebb_ge | input | 1 | Event-branch global enable |
| hv_present | input | 1 | Hypervisor mode implemented |
| wk_ext | input | 1 | Wake enable, external |
| wk_dec | input | 1 | Wake enable, decrementer |
| wk_fault | input | 1 | Wake enable, machine check and maintenance |
| wk_pdb | input | 1 | Wake enable, privileged doorbell |
| wk_hdb | input | 1 | Wake enable, hypervisor doorbell |
| wk_hvirt | input | 1 | Wake enable, hypervisor virtualization |
| hdec_ie | input | 1 | Hypervisor decrementer enable |
| hvirt_ie | input | 1 | Hypervisor virtualization enable |
| hext_blk | input | 1 | Block external delivery to hypervisor |
| ext_route | input | 1 | Partition external routing bit |
| irq_id | output | 5 | Selected identifier |
| irq_valid | output | 1 | Identifier is valid |
| wake | output | 1 | End halted state |

## Verification
Every result (identifier, valid and wake) is due exactly one clock edge after its inputs settle. The bench changes inputs just after a falling edge, lets one rising edge capture them, and compares at the following falling edge against a priority model it computes itself; one directed check also confirms that the old value still stands between the input change and that rising edge.

// File: rtl/ivp_pkg.sv
package ivp_pkg;
    localparam int IVP_NSRC = 17;
    localparam int IVP_IDW  = 5;

    localparam int SRC_RESET  = 0;
    localparam int SRC_MCHK   = 1;
    localparam int SRC_HDEC   = 2;
    localparam int SRC_HVIRT  = 3;
    localparam int SRC_EXT    = 4;
    localparam int SRC_CEXT   = 5;
    localparam int SRC_WDOG   = 6;
    localparam int SRC_CDBELL = 7;
    localparam int SRC_FIT    = 8;
    localparam int SRC_PIT    = 9;
    localparam int SRC_DEC    = 10;
    localparam int SRC_PDBELL = 11;
    localparam int SRC_HDBELL = 12;
    localparam int SRC_PERF   = 13;
    localparam int SRC_THERM  = 14;
    localparam int SRC_EBB    = 15;
    localparam int SRC_HMAINT = 16;

    typedef enum logic [1:0] {
        MODE_RUN,
        MODE_HALT_GATED,
        MODE_HALT_OPEN,
        MODE_HALT_QUIET
    } arb_mode_e;

    typedef struct packed {
        logic ee;
        logic hv;
        logic pr;
        logic ce;
        logic resume_rst;
        logic ebb_ge;
        logic hv_present;
    } core_state_t;

    typedef struct packed {
        logic wk_ext;
        logic wk_dec;
        logic wk_fault;
        logic wk_pdb;
        logic wk_hdb;
        logic wk_hvirt;
        logic hdec_ie;
        logic hvirt_ie;
        logic hext_blk;
        logic ext_route;
    } part_ctl_t;
endpackage

// File: rtl/ivp_first_pick.sv
module ivp_first_pick #(
    parameter int NSRC = 17,
    parameter int IDW  = 5
) (
    input  logic [NSRC-1:0] elig,
    output logic [IDW-1:0]  id,
    output logic            valid
);
    always_comb begin
        id    = '0;
        valid = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                id    = IDW'(i + 1);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ivp_run_select.sv
module ivp_run_select
    import ivp_pkg::*;
#(
    parameter int NSRC = IVP_NSRC
) (
    input  logic [NSRC-1:0] pend,
    input  core_state_t     cs,
    input  part_ctl_t       pc,
    output logic [NSRC-1:0] elig
);
    logic async_ok;
    logic hyp_guard;
    logic hv_blocked;

    always_comb begin
        async_ok   = cs.ee | cs.resume_rst;
        hyp_guard  = async_ok | ~cs.hv;
        hv_blocked = pc.hext_blk & cs.hv & ~cs.pr;
        elig       = '0;

        elig[SRC_RESET]  = pend[SRC_RESET];
        elig[SRC_MCHK]   = pend[SRC_MCHK];
        elig[SRC_HDEC]   = pend[SRC_HDEC]  & pc.hdec_ie  & hyp_guard;
        elig[SRC_HVIRT]  = pend[SRC_HVIRT] & pc.hvirt_ie & hyp_guard;
        elig[SRC_EXT]    = pend[SRC_EXT] &
                           ((async_ok & ~hv_blocked) |
                            (cs.hv_present & ~cs.hv & ~pc.ext_route));
        elig[SRC_CEXT]   = pend[SRC_CEXT] & cs.ce;
        elig[SRC_WDOG]   = pend[SRC_WDOG]   & async_ok;
        elig[SRC_CDBELL] = pend[SRC_CDBELL] & async_ok;
        elig[SRC_FIT]    = pend[SRC_FIT]    & async_ok;
        elig[SRC_PIT]    = pend[SRC_PIT]    & async_ok;
        elig[SRC_DEC]    = pend[SRC_DEC]    & async_ok;
        elig[SRC_PDBELL] = pend[SRC_PDBELL] & async_ok;
        elig[SRC_HDBELL] = pend[SRC_HDBELL] & async_ok;
        elig[SRC_PERF]   = pend[SRC_PERF]   & async_ok;
        elig[SRC_THERM]  = pend[SRC_THERM]  & async_ok;
        elig[SRC_EBB]    = pend[SRC_EBB] & async_ok & cs.pr & cs.ebb_ge;
        elig[SRC_HMAINT] = 1'b0;
    end
endmodule

// File: rtl/ivp_halt_select.sv
module ivp_halt_select
    import ivp_pkg::*;
#(
    parameter int NSRC = IVP_NSRC,
    parameter int IDW  = IVP_IDW
) (
    input  logic [NSRC-1:0] pend,
    input  core_state_t     cs,
    input  part_ctl_t       pc,
    output logic [IDW-1:0]  id,
    output logic            valid
);
    localparam int NWAKE = 7;
    localparam int WAKE_ORDER [NWAKE] = '{SRC_EXT, SRC_DEC, SRC_MCHK, SRC_HMAINT,
                                         SRC_PDBELL, SRC_HDBELL, SRC_HVIRT};

    logic [NWAKE-1:0] gate;

    always_comb begin
        gate[0] = pc.wk_ext & ~(pc.hext_blk & cs.hv & ~cs.pr);
        gate[1] = pc.wk_dec;
        gate[2] = pc.wk_fault;
        gate[3] = pc.wk_fault;
        gate[4] = pc.wk_pdb;
        gate[5] = pc.wk_hdb;
        gate[6] = pc.wk_hvirt;
    end

    always_comb begin
        id    = '0;
        valid = 1'b0;
        for (int k = NWAKE - 1; k >= 0; k--) begin
            if (pend[WAKE_ORDER[k]] && gate[k]) begin
                id    = IDW'(WAKE_ORDER[k] + 1);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ivp_arbiter.sv
module ivp_arbiter
    import ivp_pkg::*;
#(
    parameter int NSRC = IVP_NSRC,
    parameter int IDW  = IVP_IDW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    input  logic            ee,
    input  logic            hv,
    input  logic            pr,
    input  logic            ce,
    input  logic            halted,
    input  logic            exit_ctl,
    input  logic            resume_rst,
    input  logic            ebb_ge,
    input  logic            hv_present,
    input  logic            wk_ext,
    input  logic            wk_dec,
    input  logic            wk_fault,
    input  logic            wk_pdb,
    input  logic            wk_hdb,
    input  logic            wk_hvirt,
    input  logic            hdec_ie,
    input  logic            hvirt_ie,
    input  logic            hext_blk,
    input  logic            ext_route,
    output logic [IDW-1:0]  irq_id,
    output logic            irq_valid,
    output logic            wake
);
    localparam logic [NSRC-1:0] SYS_MASK = ~(NSRC'(1) << SRC_EBB);
    localparam logic [IDW-1:0]  RESET_ID = IDW'(SRC_RESET + 1);

    core_state_t     cs;
    part_ctl_t       pc;
    arb_mode_e       mode;
    logic [NSRC-1:0] run_elig;
    logic [IDW-1:0]  run_id;
    logic            run_valid;
    logic [IDW-1:0]  halt_id;
    logic            halt_valid;
    logic [IDW-1:0]  sel_id;
    logic            sel_valid;
    logic            wake_d;

    assign cs = '{ee: ee, hv: hv, pr: pr, ce: ce, resume_rst: resume_rst,
                  ebb_ge: ebb_ge, hv_present: hv_present};
    assign pc = '{wk_ext: wk_ext, wk_dec: wk_dec, wk_fault: wk_fault,
                  wk_pdb: wk_pdb, wk_hdb: wk_hdb, wk_hvirt: wk_hvirt,
                  hdec_ie: hdec_ie, hvirt_ie: hvirt_ie,
                  hext_blk: hext_blk, ext_route: ext_route};

    ivp_run_select #(.NSRC(NSRC)) u_run (
        .pend (pend),
        .cs   (cs),
        .pc   (pc),
        .elig (run_elig)
    );

    ivp_first_pick #(.NSRC(NSRC), .IDW(IDW)) u_pick (
        .elig  (run_elig),
        .id    (run_id),
        .valid (run_valid)
    );

    ivp_halt_select #(.NSRC(NSRC), .IDW(IDW)) u_halt (
        .pend  (pend),
        .cs    (cs),
        .pc    (pc),
        .id    (halt_id),
        .valid (halt_valid)
    );

    always_comb begin
        if (!halted)       mode = MODE_RUN;
        else if (exit_ctl) mode = MODE_HALT_GATED;
        else if (ee)       mode = MODE_HALT_OPEN;
        else               mode = MODE_HALT_QUIET;
    end

    always_comb begin
        sel_id    = '0;
        sel_valid = 1'b0;
        unique case (mode)
            MODE_RUN, MODE_HALT_OPEN: begin
                sel_id    = run_id;
                sel_valid = run_valid;
            end
            MODE_HALT_GATED: begin
                sel_id    = halt_id;
                sel_valid = halt_valid;
            end
            MODE_HALT_QUIET: begin
                sel_id    = '0;
                sel_valid = 1'b0;
            end
        endcase
        if (pend[SRC_RESET]) begin
            sel_id    = RESET_ID;
            sel_valid = 1'b1;
        end
        wake_d = (mode != MODE_RUN) &&
                 (sel_valid || (!exit_ctl && |(pend & SYS_MASK)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_id    <= '0;
            irq_valid <= 1'b0;
            wake      <= 1'b0;
        end else begin
            irq_id    <= sel_id;
            irq_valid <= sel_valid;
            wake      <= wake_d;
        end
    end
endmodule

// File: rtl/ivp_arbiter_chk.sv
module ivp_arbiter_chk
    import ivp_pkg::*;
#(
    parameter int NSRC = IVP_NSRC,
    parameter int IDW  = IVP_IDW
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] pend,
    input logic            ee,
    input logic            halted,
    input logic            exit_ctl,
    input logic [IDW-1:0]  irq_id,
    input logic            irq_valid,
    input logic            wake
);
    p_reset_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pend[SRC_RESET] |=> (irq_valid && irq_id == IDW'(SRC_RESET + 1)));

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_id == '0));

    p_quiet_nodeliver_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !exit_ctl && !ee && !pend[SRC_RESET]) |=> !irq_valid);

    p_quiet_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !exit_ctl && pend[SRC_MCHK]) |=> wake);

    p_mchk_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && pend[SRC_MCHK] && !pend[SRC_RESET])
            |=> (irq_valid && irq_id == IDW'(SRC_MCHK + 1)));

    p_no_wake_running_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> !wake);
endmodule

bind ivp_arbiter ivp_arbiter_chk #(.NSRC(NSRC), .IDW(IDW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .ee        (ee),
    .halted    (halted),
    .exit_ctl  (exit_ctl),
    .irq_id    (irq_id),
    .irq_valid (irq_valid),
    .wake      (wake)
);

// File: tb/tb_ivp_arbiter.sv
module tb_ivp_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pend = '0;
    logic ee = 0, hv = 0, pr = 0, ce = 0, halted = 0, exit_ctl = 0, resume_rst = 0;
    logic ebb_ge = 0, hv_present = 0;
    logic wk_ext = 0, wk_dec = 0, wk_fault = 0, wk_pdb = 0, wk_hdb = 0, wk_hvirt = 0;
    logic hdec_ie = 0, hvirt_ie = 0, hext_blk = 0, ext_route = 0;
    logic [4:0] irq_id;
    logic irq_valid, wake;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [31:0] lf = 32'hACE1_2357;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ivp_arbiter dut (
        .clk(clk), .rst_n(rst_n), .pend(pend), .ee(ee), .hv(hv), .pr(pr), .ce(ce),
        .halted(halted), .exit_ctl(exit_ctl), .resume_rst(resume_rst), .ebb_ge(ebb_ge),
        .hv_present(hv_present), .wk_ext(wk_ext), .wk_dec(wk_dec), .wk_fault(wk_fault),
        .wk_pdb(wk_pdb), .wk_hdb(wk_hdb), .wk_hvirt(wk_hvirt), .hdec_ie(hdec_ie),
        .hvirt_ie(hvirt_ie), .hext_blk(hext_blk), .ext_route(ext_route),
        .irq_id(irq_id), .irq_valid(irq_valid), .wake(wake)
    );

    // Reference model: returns {wake, valid, id} straight from the requirements.
    function automatic logic [6:0] model();
        logic a, g, blk;
        int id;
        logic w;
        a = ee | resume_rst;
        g = a | ~hv;
        blk = hext_blk & hv & ~pr;
        id = 0;
        if (pend[0]) id = 1;
        else if (halted && exit_ctl) begin
            if (pend[4] && wk_ext && !blk) id = 5;
            else if (pend[10] && wk_dec) id = 11;
            else if (pend[1] && wk_fault) id = 2;
            else if (pend[16] && wk_fault) id = 17;
            else if (pend[11] && wk_pdb) id = 12;
            else if (pend[12] && wk_hdb) id = 13;
            else if (pend[3] && wk_hvirt) id = 4;
        end else if (halted && !ee) id = 0;
        else begin
            if (pend[1]) id = 2;
            else if (pend[2] && hdec_ie && g) id = 3;
            else if (pend[3] && hvirt_ie && g) id = 4;
            else if (pend[4] && ((a && !blk) || (hv_present && !hv && !ext_route))) id = 5;
            else if (pend[5] && ce) id = 6;
            else if (a) begin
                for (int k = 6; k <= 14; k++)
                    if (id == 0 && pend[k]) id = k + 1;
                if (id == 0 && pend[15] && pr && ebb_ge) id = 16;
            end
        end
        w = halted && (id != 0 || (!exit_ctl && (pend & ~(17'(1) << 15)) != 0));
        return {w, id != 0, 5'(id)};
    endfunction

    function automatic string tag_of(logic [4:0] id);
        if (pend[0]) return "R1";
        if (halted && exit_ctl) return "R3";
        if (halted && !ee) return "R5";
        if (halted) return "R4";
        case (id)
            5'd0: return "R2";
            5'd2: return "R6";
            5'd3, 5'd4: return "R7";
            5'd5: return "R8";
            5'd6: return "R9";
            5'd16: return "R11";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [6:0] got, logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got wake=%0b valid=%0b id=%0d expected wake=%0b valid=%0b id=%0d",
                     tag, got[6], got[5], got[4:0], exp[6], exp[5], exp[4:0]);
        end
    endtask

    task automatic run_one(string forced);
        logic [6:0] exp;
        string tag;
        exp = model();
        tag = (forced != "") ? forced : tag_of(exp[4:0]);
        @(negedge clk);
        check(tag, {1'b0, irq_valid, irq_id}, {1'b0, exp[5:0]});
        check(exp[6] ? "R12" : tag, {wake, 6'd0}, {exp[6], 6'd0});
    endtask

    task automatic set_ctrl(logic [31:0] r);
        {ext_route, hext_blk, hvirt_ie, hdec_ie, wk_hvirt, wk_hdb, wk_pdb, wk_fault,
         wk_dec, wk_ext, hv_present, ebb_ge, resume_rst, exit_ctl, halted, ce, pr, hv, ee} = r[18:0];
    endtask

    task automatic step_lf();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R13: reset state
        pend = '1;
        repeat (2) @(negedge clk);
        check("R13", {wake, irq_valid, irq_id}, 7'd0);
        rst_n = 1'b1;
        pend = '0;
        set_ctrl(32'd0);
        @(negedge clk);
        // R2: idle
        run_one("R2");
        // R13: one-cycle latency, old value holds before the edge
        pend = 17'd1;
        #1;
        check("R13", {wake, irq_valid, irq_id}, 7'd0);
        @(negedge clk);
        check("R13", {wake, irq_valid, irq_id}, {2'b01, 5'd1});
        // R6: machine check with ee clear, running
        pend = 17'd1 << 1; set_ctrl(32'd0);
        run_one("R6");
        // R4: halted, exit clear, ee set, external pending
        pend = 17'd1 << 4; set_ctrl(32'd0); halted = 1; ee = 1;
        run_one("R4");
        // R5: quiet wake, decrementer pending
        pend = 17'd1 << 10; ee = 0;
        run_one("R5");
        // R5: event branch alone does not wake
        pend = 17'd1 << 15;
        run_one("R5");
        // R3: gated, maintenance via shared enable
        pend = 17'd1 << 16; exit_ctl = 1; wk_fault = 1;
        run_one("R3");
        // R11: event branch without problem state not taken
        set_ctrl(32'd0); ee = 1; ebb_ge = 1; pend = 17'd1 << 15;
        run_one("R11");
        pr = 1;
        run_one("R11");
        // R9: critical external needs ce
        set_ctrl(32'd0); pend = 17'd1 << 5;
        run_one("R9");
        // R12: not halted never wakes
        set_ctrl(32'd0); ee = 1; pend = 17'd1 << 6;
        run_one("R12");

        // pair sweep across all priority pairs and many gating corners
        for (int i = 0; i < N; i++) begin
            for (int j = i; j < N; j++) begin
                for (int p = 0; p < 12; p++) begin
                    step_lf();
                    set_ctrl(lf);
                    pend = (17'd1 << i) | (17'd1 << j);
                    run_one("");
                end
            end
        end
        // single-source gating sweep
        for (int i = 0; i < N; i++) begin
            for (int p = 0; p < 128; p++) begin
                step_lf();
                set_ctrl(lf);
                pend = 17'd1 << i;
                run_one("");
            end
        end
        // dense vectors, R7 and R10 ordering under many sources
        for (int p = 0; p < 400; p++) begin
            step_lf();
            set_ctrl(lf);
            step_lf();
            pend = lf[16:0] & ~17'd1;
            run_one("");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule